// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block runs host-side programmed-I/O transfers on a parallel ATA (IDE) channel. A request names one of two attached drives, a direction, a data width (16-bit word or 8-bit byte), a task-file register address with a block select, and write data. The block drives the register address and the chip select onto the cable, waits a setup time, pulses the read or write strobe for an active time, then waits a recovery time. After that it takes the next request. The drive can hold the strobe open by keeping IORDY low.

Timing is not one fixed transfer mode. Each drive has its own read timing and its own write timing, and each drive has its own address setup. Byte-wide transfers use a separate shared timing value. All timing values come in on ports that mirror the configuration registers. The block captures them when it accepts a request, so a cycle already running keeps the timing it started with. A global enable port decides whether any new cycle may start.

Each transfer passes through four phases in order: idle, setup, active and recovery. The `busy` output covers the whole transfer. The one-clock `done` pulse marks the end of the strobe, and for a read `rd_data` holds the captured word at that time.

Top module: `ide_pio_timer`

## Requirements
- R1: A request is accepted when `enable`, `req_valid` and idle coincide at a clock edge. `busy` is high from the next clock, and the phases follow in the order setup, active, recovery.
- R2: The setup phase lasts max(S,1) clocks. S is the 2-bit setup field (`setup0` or `setup1`) of the selected drive. During setup the address and chip select are driven and both strobes are high.
- R3: A word read holds `ide_dior_n` low for max(A,1) clocks and then recovers for max(Q,1) clocks. A is bits 7-4 and Q is bits 3-0 of the selected drive's read timing byte (`rd_time0` or `rd_time1`).
- R4: A word write holds `ide_diow_n` low and recovers according to the selected drive's write timing byte (`wr_time0` or `wr_time1`, same nibble layout as R3). The read timing has no effect on it.
- R5: A byte cycle takes its active count from bits 7-4 and its recovery count from bits 3-0 of `byte_time`, and ignores both drives' read and write bytes. A byte read returns zero in bits 15-8 of `rd_data`.
- R6: A count field of zero gives a phase of exactly one clock.
- R7: While `ide_iordy` is sampled low, the active phase does not end. The strobe lasts max(A,1) clocks or up to the first edge that samples IORDY high, whichever is later.
- R8: `done` is high for exactly one clock, the clock right after the last strobe clock. For a read, `rd_data` then holds `ide_din` as sampled on the edge that ended the strobe.
- R9: For a write, `ide_dout` carries the request data and `ide_dout_en` is high from the first setup clock through the last recovery clock. For a read, `ide_dout_en` stays low.
- R10: After the last recovery clock, `busy` is low for exactly one clock when `req_valid` stays high, and the next cycle starts on the following clock.
- R11: While `enable` is low, no request is accepted. `busy` and both strobes stay inactive.
- R12: The timing fields are captured at acceptance. Changing the timing ports during a cycle does not alter that cycle.
- R13: During a cycle, `ide_da` holds the request address. `req_ctrl`=0 drives `ide_cs0_n` low and `req_ctrl`=1 drives `ide_cs1_n` low. Both are held steady, and the two strobes are never low together. In idle both chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; gates acceptance of new cycles |
| req_valid | input | 1 | Request present |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = 8-bit byte cycle, 0 = 16-bit word cycle |
| req_ctrl | input | 1 | Register block select: 0 = command block, 1 = control block |
| req_addr | input | 3 | Task-file register address |
| req_wdata | input | 16 | Write data |
| rd_time0 | input | 8 | Drive 0 read timing (active 7-4, recovery 3-0) |
| wr_time0 | input | 8 | Drive 0 write timing (active 7-4, recovery 3-0) |
| setup0 | input | 2 | Drive 0 address setup clocks |
| rd_time1 | input | 8 | Drive 1 read timing |
| wr_time1 | input | 8 | Drive 1 write timing |
| setup1 | input | 2 | Drive 1 address setup clocks |
| byte_time | input | 8 | Shared byte-cycle timing (active 7-4, recovery 3-0) |
| ide_iordy | input | 1 | Drive ready; low stretches the strobe |
| ide_din | input | 16 | Data bus from the drive |
| ide_da | output | 3 | Register address to the drive |
| ide_cs0_n | output | 1 | Command block chip select, active low |
| ide_cs1_n | output | 1 | Control block chip select, active low |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dout | output | 16 | Data bus to the drive |
| ide_dout_en | output | 1 | Drive-enable for `ide_dout` |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse after the strobe ends |
| rd_data | output | 16 | Captured read data |

## Verification
A wrong phase counter or a wrong timing selection shows at the pins within the same transfer. The number of clocks with both strobes high before the strobe starts, with the strobe low, or in recovery comes out wrong, and the error is visible as soon as `busy` falls. A strobe or recovery phase that fails to end shows up as `busy` stuck high. If the IORDY qualification is lost, the strobe is shorter than the ready hold time. A mistake in capturing the request or the read data shows at the `done` pulse, as the wrong `rd_data` or a nonzero upper byte on byte reads. An address or chip select that changes while `busy` is high shows on the next clock.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  // Width of the internal phase counter; every timing field fits in it.
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } ide_phase_e;

  // A programmed count of zero still occupies one clock.
  function automatic logic [CNT_W-1:0] phase_len(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? CNT_W'(1) : raw;
  endfunction

endpackage

// File: rtl/ide_pio_tsel.sv
module ide_pio_tsel #(
  parameter int NIB_W = 4,
  parameter int SU_W  = 2
) (
  input  logic                            drive,
  input  logic                            write,
  input  logic                            byte_cyc,
  input  logic [1:0][2*NIB_W-1:0]         rd_time,
  input  logic [1:0][2*NIB_W-1:0]         wr_time,
  input  logic [1:0][SU_W-1:0]            setup,
  input  logic [2*NIB_W-1:0]              byte_time,
  output logic [SU_W-1:0]                 su_raw,
  output logic [NIB_W-1:0]                act_raw,
  output logic [NIB_W-1:0]                rec_raw
);

  logic [2*NIB_W-1:0] word_sel;
  logic [2*NIB_W-1:0] time_sel;

  always_comb begin
    word_sel = write ? wr_time[drive] : rd_time[drive];
    time_sel = byte_cyc ? byte_time : word_sel;
    act_raw  = time_sel[2*NIB_W-1:NIB_W];
    rec_raw  = time_sel[NIB_W-1:0];
    su_raw   = setup[drive];
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] su_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] rec_len,
  input  logic             iordy,
  output ide_phase_e       phase,
  output logic             evt_setup_end,
  output logic             evt_strobe_end,
  output logic             evt_cycle_end
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;
  logic             cnt_last;

  assign cnt_last       = (cnt <= CNT_W'(1));
  assign evt_setup_end  = (phase == PH_SETUP)  && cnt_last;
  assign evt_strobe_end = (phase == PH_ACTIVE) && cnt_last && iordy;
  assign evt_cycle_end  = (phase == PH_RECOV)  && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      act_q <= '0;
      rec_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= su_len;
          act_q <= act_len;
          rec_q <= rec_len;
        end
        PH_SETUP: if (evt_setup_end) begin
          phase <= PH_ACTIVE;
          cnt   <= act_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_ACTIVE: if (evt_strobe_end) begin
          phase <= PH_RECOV;
          cnt   <= rec_q;
        end else if (!cnt_last) begin
          cnt <= cnt - 1'b1;
        end
        PH_RECOV: if (evt_cycle_end) begin
          phase <= PH_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int SU_W   = 2,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_valid,
  input  logic              req_drive,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic              req_ctrl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2*NIB_W-1:0] rd_time0,
  input  logic [2*NIB_W-1:0] wr_time0,
  input  logic [SU_W-1:0]   setup0,
  input  logic [2*NIB_W-1:0] rd_time1,
  input  logic [2*NIB_W-1:0] wr_time1,
  input  logic [SU_W-1:0]   setup1,
  input  logic [2*NIB_W-1:0] byte_time,
  input  logic              ide_iordy,
  input  logic [DATA_W-1:0] ide_din,
  output logic [ADDR_W-1:0] ide_da,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [DATA_W-1:0] ide_dout,
  output logic              ide_dout_en,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BYTE_W = 8;

  function automatic logic [DATA_W-1:0] read_word(input logic [DATA_W-1:0] bus,
                                                  input logic narrow);
    return narrow ? {{(DATA_W-BYTE_W){1'b0}}, bus[BYTE_W-1:0]} : bus;
  endfunction

  // Named internal events for the checker
  logic       evt_accept;
  logic       evt_setup_end;
  logic       evt_strobe_end;
  logic       evt_cycle_end;
  ide_phase_e phase;

  logic [1:0][2*NIB_W-1:0] rd_arr;
  logic [1:0][2*NIB_W-1:0] wr_arr;
  logic [1:0][SU_W-1:0]    su_arr;
  logic [SU_W-1:0]         su_raw;
  logic [NIB_W-1:0]        act_raw;
  logic [NIB_W-1:0]        rec_raw;
  logic [CNT_W-1:0]        su_len;
  logic [CNT_W-1:0]        act_len;
  logic [CNT_W-1:0]        rec_len;

  assign rd_arr = {rd_time1, rd_time0};
  assign wr_arr = {wr_time1, wr_time0};
  assign su_arr = {setup1, setup0};

  ide_pio_tsel #(.NIB_W(NIB_W), .SU_W(SU_W)) u_tsel (
    .drive     (req_drive),
    .write     (req_write),
    .byte_cyc  (req_byte),
    .rd_time   (rd_arr),
    .wr_time   (wr_arr),
    .setup     (su_arr),
    .byte_time (byte_time),
    .su_raw    (su_raw),
    .act_raw   (act_raw),
    .rec_raw   (rec_raw)
  );

  assign su_len  = phase_len({{(CNT_W-SU_W){1'b0}}, su_raw});
  assign act_len = phase_len({{(CNT_W-NIB_W){1'b0}}, act_raw});
  assign rec_len = phase_len({{(CNT_W-NIB_W){1'b0}}, rec_raw});

  assign evt_accept = enable && req_valid && (phase == PH_IDLE);

  ide_pio_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (evt_accept),
    .su_len         (su_len),
    .act_len        (act_len),
    .rec_len        (rec_len),
    .iordy          (ide_iordy),
    .phase          (phase),
    .evt_setup_end  (evt_setup_end),
    .evt_strobe_end (evt_strobe_end),
    .evt_cycle_end  (evt_cycle_end)
  );

  // Request capture
  logic              wr_q;
  logic              byte_q;
  logic              ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      ctrl_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (evt_accept) begin
      wr_q    <= req_write;
      byte_q  <= req_byte;
      ctrl_q  <= req_ctrl;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Completion pulse and read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= evt_strobe_end;
      if (evt_strobe_end && !wr_q) rd_data <= read_word(ide_din, byte_q);
    end
  end

  logic in_cycle;
  logic strobing;

  assign in_cycle    = (phase != PH_IDLE);
  assign strobing    = (phase == PH_ACTIVE);
  assign busy        = in_cycle;
  assign ide_dior_n  = !(strobing && !wr_q);
  assign ide_diow_n  = !(strobing && wr_q);
  assign ide_cs0_n   = !(in_cycle && !ctrl_q);
  assign ide_cs1_n   = !(in_cycle && ctrl_q);
  assign ide_da      = in_cycle ? addr_q : '0;
  assign ide_dout    = wdata_q;
  assign ide_dout_en = in_cycle && wr_q;

endmodule

// File: rtl/ide_pio_timer_chk.sv
module ide_pio_timer_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              ide_iordy,
  input logic [ADDR_W-1:0] ide_da,
  input logic              ide_cs0_n,
  input logic              ide_cs1_n,
  input logic              ide_dior_n,
  input logic              ide_diow_n,
  input logic [DATA_W-1:0] ide_dout,
  input logic              ide_dout_en,
  input logic              busy,
  input logic              done,
  input logic              evt_accept,
  input logic              evt_strobe_end
);

  logic stb;
  assign stb = !ide_dior_n || !ide_diow_n;

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));

  // R13
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ide_da) && $stable(ide_cs0_n) && $stable(ide_cs1_n)));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy);

  // R7
  iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !ide_iordy) |=> stb);

  // R8
  done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(stb));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  strobe_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_strobe_end |=> (done && !stb));

  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_dout_en && $past(ide_dout_en)) |-> $stable(ide_dout));

  // R9
  dout_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dout_en |-> busy);

  // R11
  idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy);

endmodule

bind ide_pio_timer ide_pio_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .ide_iordy      (ide_iordy),
  .ide_da         (ide_da),
  .ide_cs0_n      (ide_cs0_n),
  .ide_cs1_n      (ide_cs1_n),
  .ide_dior_n     (ide_dior_n),
  .ide_diow_n     (ide_diow_n),
  .ide_dout       (ide_dout),
  .ide_dout_en    (ide_dout_en),
  .busy           (busy),
  .done           (done),
  .evt_accept     (evt_accept),
  .evt_strobe_end (evt_strobe_end)
);

// File: tb/ide_pio_timer_tb.sv
`timescale 1ns/1ps
module ide_pio_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_drive = 1'b0;
  logic        req_write = 1'b0;
  logic        req_byte = 1'b0;
  logic        req_ctrl = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  rd_time0 = '0, wr_time0 = '0, rd_time1 = '0, wr_time1 = '0, byte_time = '0;
  logic [1:0]  setup0 = '0, setup1 = '0;
  logic        ide_iordy = 1'b1;
  logic [15:0] ide_din = '0;
  logic [2:0]  ide_da;
  logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dout_en, busy, done;
  logic [15:0] ide_dout, rd_data;

  always #5 clk = ~clk;

  ide_pio_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
    .req_drive(req_drive), .req_write(req_write), .req_byte(req_byte),
    .req_ctrl(req_ctrl), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_time0(rd_time0), .wr_time0(wr_time0), .setup0(setup0),
    .rd_time1(rd_time1), .wr_time1(wr_time1), .setup1(setup1),
    .byte_time(byte_time), .ide_iordy(ide_iordy), .ide_din(ide_din),
    .ide_da(ide_da), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n), .ide_dout(ide_dout),
    .ide_dout_en(ide_dout_en), .busy(busy), .done(done), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  // Vector: {drv, wr, byte, ctl, su[1:0], act[3:0], rec[3:0], addr[2:0], data[15:0]}
  localparam int NV = 7;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd3,  4'd2,  3'd0, 16'hA5C3},
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd5,  4'd1,  3'd7, 16'h1234},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0,  4'd0,  3'd1, 16'hBEEF},
    {1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 4'd4,  4'd6,  3'd6, 16'h5A5A},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2,  4'd3,  3'd0, 16'hF00D},
    {1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 4'd6,  4'd2,  3'd0, 16'h00C7},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 4'd15, 4'd15, 3'd6, 16'h8181}
  };

  // Measurements taken during one cycle
  int          m_su, m_act, m_rec, m_done;
  logic [15:0] m_rd, m_do;
  bit          m_doen, m_cs0, m_cs1;
  logic [2:0]  m_da;

  function automatic int at_least_one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_cycle(input bit drv, input bit wr, input bit byt, input bit ctl,
                           input logic [2:0] addr, input logic [15:0] data,
                           input int hold, input bit mutate);
    bit seen;
    m_su = 0; m_act = 0; m_rec = 0; m_done = 0;
    m_rd = '0; m_do = '0; m_doen = 0; m_cs0 = 1; m_cs1 = 1; m_da = '0;
    seen = 0;
    @(negedge clk);
    req_drive = drv; req_write = wr; req_byte = byt; req_ctrl = ctl;
    req_addr = addr; req_wdata = data; ide_din = data;
    ide_iordy = (hold == 0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mutate) begin
      rd_time0 = 8'hF0; rd_time1 = 8'hF0; setup0 = 2'd3; setup1 = 2'd3; byte_time = 8'hF0;
    end
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      if (!ide_dior_n || !ide_diow_n) begin
        m_act++; seen = 1;
        m_da = ide_da; m_cs0 = ide_cs0_n; m_cs1 = ide_cs1_n;
        m_do = ide_dout; m_doen = ide_dout_en;
        if (m_act >= hold) ide_iordy = 1'b1;
      end else if (!seen) begin
        m_su++;
      end else begin
        m_rec++;
      end
      if (done) begin
        m_done++; m_rd = rd_data;
      end
      @(negedge clk);
    end
    ide_iordy = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset busy", busy, 0);
    chk("R13 reset strobes", {ide_dior_n, ide_diow_n}, 2'b11);
    chk("R13 reset chip selects", {ide_cs0_n, ide_cs1_n}, 2'b11);
    chk("R8 reset done", done, 0);
    chk("R9 reset dout_en", ide_dout_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: disabled block ignores a request
    req_valid = 1'b1;
    begin
      int act_seen;
      act_seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || !ide_dior_n || !ide_diow_n) act_seen++;
      end
      chk("R11 no cycle while disabled", act_seen, 0);
    end
    req_valid = 1'b0;
    enable = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R9 R13
    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      logic [7:0]  tgt, junk;
      logic [1:0]  su;
      int          exp_s, exp_a, exp_r;
      logic [15:0] exp_rd;
      e = VEC[v];
      su = e[28:27];
      tgt = e[26:19];
      junk = ~tgt;
      rd_time0 = junk; rd_time1 = junk; wr_time0 = junk; wr_time1 = junk; byte_time = junk;
      if (e[30]) byte_time = tgt;
      else if (e[31]) begin if (e[32]) wr_time1 = tgt; else wr_time0 = tgt; end
      else begin if (e[32]) rd_time1 = tgt; else rd_time0 = tgt; end
      if (e[32]) begin setup1 = su; setup0 = ~su; end
      else begin setup0 = su; setup1 = ~su; end
      run_cycle(e[32], e[31], e[30], e[29], e[18:16], e[15:0], 0, 0);
      exp_s = at_least_one(int'(su));
      exp_a = at_least_one(int'(tgt[7:4]));
      exp_r = at_least_one(int'(tgt[3:0]));
      chk($sformatf("R2 R6 setup clocks v%0d", v), m_su, exp_s);
      chk($sformatf("R3 R4 R5 R6 active clocks v%0d", v), m_act, exp_a);
      chk($sformatf("R3 R4 R5 R6 recovery clocks v%0d", v), m_rec, exp_r);
      chk($sformatf("R8 done pulses v%0d", v), m_done, 1);
      chk($sformatf("R13 address v%0d", v), m_da, e[18:16]);
      chk($sformatf("R13 chip selects v%0d", v), {m_cs0, m_cs1}, e[29] ? 2'b10 : 2'b01);
      if (e[31]) begin
        chk($sformatf("R9 write data v%0d", v), m_do, e[15:0]);
        chk($sformatf("R9 dout_en write v%0d", v), m_doen, 1);
      end else begin
        exp_rd = e[30] ? {8'h00, e[7:0]} : e[15:0];
        chk($sformatf("R5 R8 read data v%0d", v), m_rd, exp_rd);
        chk($sformatf("R9 dout_en read v%0d", v), m_doen, 0);
      end
    end

    // R7: IORDY low stretches the strobe past the active count
    rd_time0 = 8'h21; setup0 = 2'd1;
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 16'h0F0F, 6, 0);
    chk("R7 strobe stretched by iordy", m_act, 6);
    chk("R7 recovery after stretch", m_rec, 1);
    rd_time0 = 8'h41;
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 16'h0F0F, 2, 0);
    chk("R7 early iordy keeps active count", m_act, 4);

    // R12: timing change during a cycle has no effect on it
    rd_time0 = 8'h32; setup0 = 2'd2; byte_time = 8'h11;
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 16'h4321, 0, 1);
    chk("R12 setup kept", m_su, 2);
    chk("R12 active kept", m_act, 3);
    chk("R12 recovery kept", m_rec, 2);

    // R10: back-to-back cycles with req_valid held high
    rd_time0 = 8'h11; setup0 = 2'd1;
    @(negedge clk);
    req_drive = 1'b0; req_write = 1'b0; req_byte = 1'b0; req_valid = 1'b1;
    begin
      int lows;
      logic [7:0] pat;
      lows = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        pat[7-i] = busy;
        if (!busy) lows++;
      end
      chk("R10 busy pattern back-to-back", pat, 8'b1110_1110);
      chk("R10 idle gap clocks", lows, 2);
    end
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 busy falls after last cycle", busy, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule